// File: doc/BRIEF.md
# Power-Good Strap Sampling Latch

This block captures a small set of configuration straps exactly once, at the moment an active-low power-good input is first seen asserted. The straps are a three-bit CPU frequency code, a two-bit function code for two differential output pin pairs, and a one-bit mode strap for a pair of request pins. All strap inputs, the power-good input and the test-mode input pass through a multi-stage synchronizer first. On the first clock where the synchronized power-good is low, the latch stores the synchronized straps. Later activity on power-good or on the straps is ignored.

The stored straps are held on the outputs. One registered stage after the capture, they are decoded into a CPU clock rate code, a selection for each of the two pin pairs, and the request-pin mode, and a configured flag rises. The configured flag therefore marks the point where the decoded outputs are valid. A test-mode input re-opens the latch: while it is high and power-good is low, the latch follows the straps on every cycle. Reset is synchronous and active high. It returns everything to the defaults and arms a new capture.

Top module: `pwrgd_strap_latch`

## Requirements
- R1: While reset is high and in the cycle after it is released, configured is 0, lat_fs is 3'b101, lat_fct is 2'b00, lat_req is 0, cpu_rate is 0, pair_a_sel is 0, pair_b_src is 0 and src9_en is 0.
- R2: If pwrgd_n falls just after a clock edge, the latched strap outputs are unchanged after two more edges and carry the new strap values after the third edge. configured and the decoded outputs take effect after the fourth edge.
- R3: Once a capture has happened and test_mode is 0, later changes on the straps and on pwrgd_n (going high and low again included) leave every output unchanged.
- R4: While test_mode is 1 and pwrgd_n is low, the latched outputs follow the straps with the same delay as in R2. While test_mode is 1 and pwrgd_n is high, they hold.
- R5: cpu_rate decodes {FSC,FSB,FSA} = lat_fs[2:0]: 101 gives 0 (100 MHz), 001 gives 1 (133 MHz), 011 gives 2 (166 MHz), 010 gives 3 (200 MHz), and every other code gives 0.
- R6: pair_a_sel decodes lat_fct: 00 and 10 give 0 (96 MHz pair), 01 gives 1 (27 MHz non-spread and spread), 11 gives 2 (pair off/low).
- R7: pair_b_src is 0 (100 MHz spread pair) when lat_fct is 00, and 1 (SRC pair 0) for every other code.
- R8: src9_en equals lat_req: 0 keeps request A/B pin behaviour, 1 turns those pins into SRC pair 9.
- R9: While pwrgd_n stays high, strap changes do not reach any output and configured stays 0.
- R10: configured stays 1 until reset. A reset then restores the R1 values and permits a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd_n | input | 1 | Active-low power-good |
| test_mode | input | 1 | Re-opens the latch while power-good is low |
| fs_strap | input | 3 | Frequency straps {FSC,FSB,FSA} |
| fct_strap | input | 2 | Pin-pair function straps |
| req_strap | input | 1 | Request-pin mode strap |
| lat_fs | output | 3 | Latched frequency straps |
| lat_fct | output | 2 | Latched function straps |
| lat_req | output | 1 | Latched request-pin strap |
| cpu_rate | output | 2 | CPU rate code (0:100, 1:133, 2:166, 3:200 MHz) |
| pair_a_sel | output | 2 | First pair: 0 96 MHz, 1 27 MHz, 2 off |
| pair_b_src | output | 1 | Second pair: 0 100 MHz spread, 1 SRC pair 0 |
| src9_en | output | 1 | Request pins act as SRC pair 9 |
| configured | output | 1 | Decoded outputs valid |

## Verification
The hardest case to reach is the one-shot property: power-good goes high after a capture and then low again while the straps differ. Without test mode this must not produce a second capture. The bench drives exactly that sequence with new strap values and checks that the old decode remains. It then repeats the sequence with test mode high, where the new values must appear. Full coverage of the decode needs a fresh power-up for each code, so the bench resets before every sweep point and lets one capture occur.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int FS_W  = 3;
  localparam int FCT_W = 2;

  typedef struct packed {
    logic [FS_W-1:0]  fs;
    logic [FCT_W-1:0] fct;
    logic             req;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);

  localparam strap_t STRAP_DEFAULT = '{fs: 3'b101, fct: 2'b00, req: 1'b0};

  typedef enum logic [1:0] {
    RATE_100 = 2'd0,
    RATE_133 = 2'd1,
    RATE_166 = 2'd2,
    RATE_200 = 2'd3
  } cpu_rate_e;

  typedef enum logic [1:0] {
    PA_DOT96 = 2'd0,
    PA_CLK27 = 2'd1,
    PA_OFF   = 2'd2
  } pair_a_e;

  function automatic cpu_rate_e rate_of(input logic [FS_W-1:0] code);
    case (code)
      3'b001:  return RATE_133;
      3'b011:  return RATE_166;
      3'b010:  return RATE_200;
      default: return RATE_100;
    endcase
  endfunction

  function automatic pair_a_e pair_a_of(input logic [FCT_W-1:0] code);
    case (code)
      2'b01:   return PA_CLK27;
      2'b11:   return PA_OFF;
      default: return PA_DOT96;
    endcase
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pg_n_s,
  input  logic   test_s,
  input  strap_t straps_s,
  output strap_t latched,
  output logic   captured
);

  logic take;

  // a capture is allowed once, or on every cycle while test mode re-opens it
  assign take = !pg_n_s && (!captured || test_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      latched  <= STRAP_DEFAULT;
      captured <= 1'b0;
    end else if (take) begin
      latched  <= straps_s;
      captured <= 1'b1;
    end
  end

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    pg_n_s |=> $stable(latched));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (captured && !test_s) |=> $stable(latched));

endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  strap_t    lat,
  input  logic      captured,
  output cpu_rate_e rate,
  output pair_a_e   pair_a,
  output logic      pair_b_src,
  output logic      src9_en,
  output logic      configured
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate       <= RATE_100;
      pair_a     <= PA_DOT96;
      pair_b_src <= 1'b0;
      src9_en    <= 1'b0;
      configured <= 1'b0;
    end else begin
      rate       <= rate_of(lat.fs);
      pair_a     <= pair_a_of(lat.fct);
      pair_b_src <= (lat.fct != 2'b00);
      src9_en    <= lat.req;
      configured <= captured;
    end
  end

  p_rate200_r5: assert property (@(posedge clk) disable iff (rst)
    (lat.fs == 3'b010) |=> (rate == RATE_200));

  p_off_r6: assert property (@(posedge clk) disable iff (rst)
    (lat.fct == 2'b11) |=> (pair_a == PA_OFF));

  p_cfg_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    configured |=> configured);

endmodule

// File: rtl/pwrgd_strap_latch.sv
module pwrgd_strap_latch
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrgd_n,
  input  logic             test_mode,
  input  logic [FS_W-1:0]  fs_strap,
  input  logic [FCT_W-1:0] fct_strap,
  input  logic             req_strap,
  output logic [FS_W-1:0]  lat_fs,
  output logic [FCT_W-1:0] lat_fct,
  output logic             lat_req,
  output logic [1:0]       cpu_rate,
  output logic [1:0]       pair_a_sel,
  output logic             pair_b_src,
  output logic             src9_en,
  output logic             configured
);

  localparam int SYNC_W = STRAP_W + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, STRAP_DEFAULT};

  logic [SYNC_W-1:0] sync_d, sync_q;
  strap_t            straps_s, latched;
  logic              pg_n_s, test_s, captured;
  cpu_rate_e         rate;
  pair_a_e           pair_a;

  assign sync_d = {test_mode, pwrgd_n, fs_strap, fct_strap, req_strap};

  strap_sync #(
    .W       (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_d),
    .q   (sync_q)
  );

  assign test_s   = sync_q[SYNC_W-1];
  assign pg_n_s   = sync_q[SYNC_W-2];
  assign straps_s = strap_t'(sync_q[STRAP_W-1:0]);

  strap_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .pg_n_s   (pg_n_s),
    .test_s   (test_s),
    .straps_s (straps_s),
    .latched  (latched),
    .captured (captured)
  );

  strap_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .lat        (latched),
    .captured   (captured),
    .rate       (rate),
    .pair_a     (pair_a),
    .pair_b_src (pair_b_src),
    .src9_en    (src9_en),
    .configured (configured)
  );

  assign lat_fs     = latched.fs;
  assign lat_fct    = latched.fct;
  assign lat_req    = latched.req;
  assign cpu_rate   = rate;
  assign pair_a_sel = pair_a;

endmodule

// File: tb/pwrgd_strap_latch_test.sv
module pwrgd_strap_latch_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwrgd_n = 1'b1;
  logic       test_mode = 1'b0;
  logic [2:0] fs_strap = 3'b000;
  logic [1:0] fct_strap = 2'b00;
  logic       req_strap = 1'b0;
  logic [2:0] lat_fs;
  logic [1:0] lat_fct;
  logic       lat_req;
  logic [1:0] cpu_rate;
  logic [1:0] pair_a_sel;
  logic       pair_b_src;
  logic       src9_en;
  logic       configured;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    fs, fct, req, rate, pa, pb, s9, cfg;
    string tag;
  } exp_t;

  exp_t q[$];
  event mon_ev;

  pwrgd_strap_latch uut (
    .clk (clk), .rst (rst), .pwrgd_n (pwrgd_n), .test_mode (test_mode),
    .fs_strap (fs_strap), .fct_strap (fct_strap), .req_strap (req_strap),
    .lat_fs (lat_fs), .lat_fct (lat_fct), .lat_req (lat_req),
    .cpu_rate (cpu_rate), .pair_a_sel (pair_a_sel), .pair_b_src (pair_b_src),
    .src9_en (src9_en), .configured (configured)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_rate(input int fs);
    case (fs)
      1: return 1;
      3: return 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int m_pa(input int fct);
    case (fct)
      1: return 1;
      3: return 2;
      default: return 0;
    endcase
  endfunction

  // driver side: expected state computed from requirements, queued for the monitor
  task automatic expect_state(input int fs, input int fct, input int req,
                              input int cfg, input string tag);
    exp_t e;
    e.fs = fs; e.fct = fct; e.req = req;
    e.rate = m_rate(fs); e.pa = m_pa(fct); e.pb = (fct != 0); e.s9 = req;
    e.cfg = cfg; e.tag = tag;
    q.push_back(e);
    ->mon_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " lat_fs"},     lat_fs,     e.fs);
        chk({e.tag, " lat_fct"},    lat_fct,    e.fct);
        chk({e.tag, " lat_req"},    lat_req,    e.req);
        chk({e.tag, " cpu_rate"},   cpu_rate,   e.rate);
        chk({e.tag, " pair_a_sel"}, pair_a_sel, e.pa);
        chk({e.tag, " pair_b_src"}, pair_b_src, e.pb);
        chk({e.tag, " src9_en"},    src9_en,    e.s9);
        chk({e.tag, " configured"}, configured, e.cfg);
      end
    end
  end

  task automatic do_reset();
    pwrgd_n = 1'b1;
    test_mode = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_straps(input int fs, input int fct, input int req);
    fs_strap = 3'(fs);
    fct_strap = 2'(fct);
    req_strap = 1'(req);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    expect_state(5, 0, 0, 0, "R1 after reset");

    // straps move while power-good stays high
    for (int i = 0; i < 6; i++) begin
      set_straps(i, i % 4, i % 2);
      @(negedge clk);
    end
    expect_state(5, 0, 0, 0, "R9 straps before power-good");

    // exact capture latency
    set_straps(1, 1, 1);
    pwrgd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 lat_fs after 2 edges", lat_fs, 5);
    @(negedge clk);
    chk("R2 lat_fs after 3 edges", lat_fs, 1);
    chk("R2 configured after 3 edges", configured, 0);
    chk("R2 cpu_rate after 3 edges", cpu_rate, 0);
    @(negedge clk);
    expect_state(1, 1, 1, 1, "R2 after 4 edges");

    // one-shot: straps change, power-good bounces
    set_straps(2, 3, 0);
    repeat (3) @(negedge clk);
    pwrgd_n = 1'b1;
    repeat (4) @(negedge clk);
    pwrgd_n = 1'b0;
    repeat (6) @(negedge clk);
    expect_state(1, 1, 1, 1, "R3 ignored after capture");
    chk("R10 configured still high", configured, 1);

    // test mode reopens the latch
    test_mode = 1'b1;
    repeat (6) @(negedge clk);
    expect_state(2, 3, 0, 1, "R4 test mode follows");
    set_straps(3, 2, 1);
    repeat (6) @(negedge clk);
    expect_state(3, 2, 1, 1, "R4 test mode follows again");
    pwrgd_n = 1'b1;
    repeat (3) @(negedge clk);
    set_straps(0, 0, 0);
    repeat (6) @(negedge clk);
    expect_state(3, 2, 1, 1, "R4 test mode power-good high holds");
    test_mode = 1'b0;
    pwrgd_n = 1'b0;
    repeat (6) @(negedge clk);
    expect_state(3, 2, 1, 1, "R3 test mode off holds");

    // reset restores defaults and rearms
    do_reset();
    expect_state(5, 0, 0, 0, "R10 reset restores");
    set_straps(0, 3, 0);
    pwrgd_n = 1'b0;
    repeat (6) @(negedge clk);
    expect_state(0, 3, 0, 1, "R10 recapture");

    // decode sweep, one power-up per code
    for (int i = 0; i < 8; i++) begin
      do_reset();
      set_straps(i, (i + 1) % 4, i % 2);
      pwrgd_n = 1'b0;
      repeat (6) @(negedge clk);
      expect_state(i, (i + 1) % 4, i % 2, 1, "R5 R6 R7 R8 sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule